// File: doc/BRIEF.md
# Shift-and-Add Four-Tap FIR Filter

This block is a four-tap direct-form FIR filter whose coefficients are fixed at design time. It uses no multipliers. Every coefficient is split into signed power-of-two terms, and each term becomes an arithmetic right shift of a tap followed by an add or a subtract. Each time the strobe `in_valid` is high, the block accepts one signed fractional sample. It keeps the three previous accepted samples in a delay line and returns one filtered, saturated sample one clock later.

The current tap (weight 59/128) and the tap two samples back (weight -77/128) share four shift positions. Their sum is therefore formed once, and that one sum is shifted four times. With the shared sum, the network costs 13 additions. Without it, the same network costs 16. A parameter selects between the shared network and the flat network, and both give bit-identical results.

The internal datapath carries 7 fractional guard bits and 3 integer guard bits on top of the 16 sample bits. The full-precision inner product is therefore exact. Only the final conversion back to 16 bits loses information: it rounds toward minus infinity and then clamps to the output range.

Top module: `fir_shift_add`

## Requirements
- R1: While `rst` is high at a rising clock edge, the delay line is cleared and the outputs are set to `out_valid`=0 and `out_sample`=0. The first sample accepted after reset is filtered against three zero history samples.
- R2: The delay line advances only on edges where `in_valid` is high. The value on `in_sample` during cycles with `in_valid` low has no effect on any later output.
- R3: Samples are 16-bit two's complement values with 15 fraction bits. For an accepted sample x0 with history x1, x2, x3 (newest first), the result is floor((59*x0 + 46*x1 - 77*x2 + 38*x3) / 128) in raw integer codes, provided it lies in [-32768, 32767].
- R4: Rounding is toward minus infinity. With a zero history, an input of -1 LSB produces -1 (0xFFFF), and an input of +1 LSB produces 0.
- R5: `out_valid` equals the `in_valid` value from the previous edge. `out_sample` changes only on the edge after an accepted sample and holds its value otherwise.
- R6: A result above 32767 produces exactly 0x7FFF, including the worst-case positive operand set, and never wraps to a negative value.
- R7: A result below -32768 produces exactly 0x8000, including the worst-case negative operand set, and never wraps to a positive value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; the sample is accepted on the edge where this is high |
| in_sample | input | 16 | Signed fractional input sample |
| out_valid | output | 1 | High for one cycle per accepted sample |
| out_sample | output | 16 | Filtered, rounded and saturated output sample |

## Verification
The delay line affects every later output. A tap that shifts when it should not, or that misses a shift, gives a wrong output within at most three accepted samples. An impulse at the input exposes each coefficient alone, one per output. A single wrong shift amount, a wrong sign, or a missing term in the shared sum therefore changes one of those four outputs by an exactly predictable amount. An undersized guard field shows up only near full scale, as a wrapped output with the wrong sign, so alternating full-scale runs are aimed at both saturation rails. A long pseudo-random run with gaps in the strobe covers arbitrary mixes of history.

// File: rtl/fir_sa_pkg.sv
package fir_sa_pkg;

   localparam int NUM_TAPS       = 4;
   localparam int SHIFT_W        = 3;
   localparam int N_TERMS_SHARED = 13;
   localparam int N_TERMS_FLAT   = 17;

   // Integer tap weights in units of 2^-WEIGHT_FRAC (used as the arithmetic reference).
   localparam int WEIGHT_FRAC = 7;
   localparam int WEIGHT_0    = 59;
   localparam int WEIGHT_1    = 46;
   localparam int WEIGHT_2    = -77;
   localparam int WEIGHT_3    = 38;

   typedef enum logic [2:0] {
      SRC_CUR  = 3'd0,
      SRC_D1   = 3'd1,
      SRC_D2   = 3'd2,
      SRC_D3   = 3'd3,
      SRC_PAIR = 3'd4
   } term_src_e;

   typedef struct packed {
      term_src_e          src;
      logic [SHIFT_W-1:0] shamt;
      logic               neg;
   } term_t;

   function automatic term_t mk_term(input term_src_e s, input int sh, input bit n);
      term_t t;
      t.src   = s;
      t.shamt = SHIFT_W'(sh);
      t.neg   = n;
      return t;
   endfunction

   // Terms with the current and second-delayed taps merged into one shared pair sum.
   function automatic term_t shared_term(input int idx);
      case (idx)
         0:       return mk_term(SRC_PAIR, 2, 1'b0);
         1:       return mk_term(SRC_PAIR, 3, 1'b0);
         2:       return mk_term(SRC_PAIR, 6, 1'b0);
         3:       return mk_term(SRC_PAIR, 7, 1'b0);
         4:       return mk_term(SRC_CUR,  4, 1'b0);
         5:       return mk_term(SRC_D2,   0, 1'b1);
         6:       return mk_term(SRC_D1,   2, 1'b0);
         7:       return mk_term(SRC_D1,   4, 1'b0);
         8:       return mk_term(SRC_D1,   5, 1'b0);
         9:       return mk_term(SRC_D1,   6, 1'b0);
         10:      return mk_term(SRC_D3,   2, 1'b0);
         11:      return mk_term(SRC_D3,   5, 1'b0);
         default: return mk_term(SRC_D3,   6, 1'b0);
      endcase
   endfunction

   // Terms with every coefficient expanded on its own tap.
   function automatic term_t flat_term(input int idx);
      case (idx)
         0:       return mk_term(SRC_CUR, 2, 1'b0);
         1:       return mk_term(SRC_CUR, 3, 1'b0);
         2:       return mk_term(SRC_CUR, 4, 1'b0);
         3:       return mk_term(SRC_CUR, 6, 1'b0);
         4:       return mk_term(SRC_CUR, 7, 1'b0);
         5:       return mk_term(SRC_D1,  2, 1'b0);
         6:       return mk_term(SRC_D1,  4, 1'b0);
         7:       return mk_term(SRC_D1,  5, 1'b0);
         8:       return mk_term(SRC_D1,  6, 1'b0);
         9:       return mk_term(SRC_D2,  0, 1'b1);
         10:      return mk_term(SRC_D2,  2, 1'b0);
         11:      return mk_term(SRC_D2,  3, 1'b0);
         12:      return mk_term(SRC_D2,  6, 1'b0);
         13:      return mk_term(SRC_D2,  7, 1'b0);
         14:      return mk_term(SRC_D3,  2, 1'b0);
         15:      return mk_term(SRC_D3,  5, 1'b0);
         default: return mk_term(SRC_D3,  6, 1'b0);
      endcase
   endfunction

endpackage

// File: rtl/fir_sa_delay.sv
module fir_sa_delay #(
   parameter int W     = 16,
   parameter int DEPTH = 3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      shift_i,
   input  logic [W-1:0]              sample_i,
   output logic [DEPTH-1:0][W-1:0]   taps_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("fir_sa_delay: DEPTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         taps_o <= '0;
      end else if (shift_i) begin
         taps_o[0] <= sample_i;
         for (int s = 1; s < DEPTH; s++) begin
            taps_o[s] <= taps_o[s-1];
         end
      end
   end

   // R2: history is frozen on cycles without a strobe
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !shift_i |=> $stable(taps_o));

   // R2: newest history slot captures the accepted sample
   a_r2_capture: assert property (@(posedge clk) disable iff (rst)
      shift_i |=> taps_o[0] == $past(sample_i));

endmodule

// File: rtl/fir_sa_network.sv
module fir_sa_network
   import fir_sa_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int FRAC_G    = 7,
   parameter int INT_G     = 3,
   parameter bit SHARE_SUM = 1'b1,
   localparam int ACC_W    = IN_W + FRAC_G + INT_G
) (
   input  logic [NUM_TAPS-1:0][IN_W-1:0] samples_i,
   output logic signed [ACC_W-1:0]       acc_o
);

   // Each tap placed on the common grid: integer guard, sample, fractional guard.
   logic signed [ACC_W-1:0] ext [NUM_TAPS];

   for (genvar k = 0; k < NUM_TAPS; k++) begin : g_align
      assign ext[k] = {{INT_G{samples_i[k][IN_W-1]}}, samples_i[k], {FRAC_G{1'b0}}};
   end

   if (SHARE_SUM) begin : g_shared
      logic signed [ACC_W-1:0] pair_sum;
      logic signed [ACC_W-1:0] part [N_TERMS_SHARED+1];

      assign pair_sum = ext[0] + ext[2];
      assign part[0]  = '0;

      for (genvar i = 0; i < N_TERMS_SHARED; i++) begin : g_term
         localparam term_t T = shared_term(i);
         logic signed [ACC_W-1:0] opnd;

         if (T.src == SRC_PAIR) begin : g_pair
            assign opnd = pair_sum >>> T.shamt;
         end else begin : g_tap
            assign opnd = ext[int'(T.src)] >>> T.shamt;
         end

         if (T.neg) begin : g_sub
            // subtract: inverted operand plus a carry of one at the LSB
            assign part[i+1] = part[i] + ~opnd + ACC_W'(1);
         end else begin : g_add
            assign part[i+1] = part[i] + opnd;
         end
      end

      assign acc_o = part[N_TERMS_SHARED];
   end else begin : g_flat
      logic signed [ACC_W-1:0] part [N_TERMS_FLAT+1];

      assign part[0] = '0;

      for (genvar i = 0; i < N_TERMS_FLAT; i++) begin : g_term
         localparam term_t T = flat_term(i);
         logic signed [ACC_W-1:0] opnd;

         assign opnd = ext[int'(T.src)] >>> T.shamt;

         if (T.neg) begin : g_sub
            assign part[i+1] = part[i] + ~opnd + ACC_W'(1);
         end else begin : g_add
            assign part[i+1] = part[i] + opnd;
         end
      end

      assign acc_o = part[N_TERMS_FLAT];
   end

endmodule

// File: rtl/fir_sa_saturate.sv
module fir_sa_saturate #(
   parameter int IN_W     = 16,
   parameter int FRAC_G   = 7,
   parameter int INT_G    = 3,
   localparam int ACC_W   = IN_W + FRAC_G + INT_G,
   localparam int TRUNC_W = IN_W + INT_G
) (
   input  logic signed [ACC_W-1:0] acc_i,
   output logic [IN_W-1:0]         sample_o
);

   localparam logic [IN_W-1:0] POS_RAIL = {1'b0, {(IN_W-1){1'b1}}};
   localparam logic [IN_W-1:0] NEG_RAIL = {1'b1, {(IN_W-1){1'b0}}};

   logic [TRUNC_W-1:0] trunc;
   logic [INT_G:0]     head;
   logic               in_range;
   logic               unused_frac_bits;

   // Dropping the fractional guard bits of a two's complement value floors it.
   assign trunc            = acc_i[ACC_W-1:FRAC_G];
   assign unused_frac_bits = ^acc_i[FRAC_G-1:0];
   assign head             = trunc[TRUNC_W-1:IN_W-1];
   assign in_range         = (&head) | ~(|head);

   always_comb begin
      if (in_range) begin
         sample_o = trunc[IN_W-1:0];
      end else if (trunc[TRUNC_W-1]) begin
         sample_o = NEG_RAIL;
      end else begin
         sample_o = POS_RAIL;
      end
   end

endmodule

// File: rtl/fir_shift_add.sv
module fir_shift_add
   import fir_sa_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int FRAC_G    = 7,
   parameter int INT_G     = 3,
   parameter bit SHARE_SUM = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_sample,
   output logic            out_valid,
   output logic [IN_W-1:0] out_sample
);

   localparam int ACC_W  = IN_W + FRAC_G + INT_G;
   localparam int HIST_N = NUM_TAPS - 1;
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(1) << (IN_W - 1 + FRAC_G);
   localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI;

   if (IN_W < 2) begin : g_bad_in_w
      $error("fir_shift_add: IN_W must be at least 2");
   end
   if (FRAC_G < WEIGHT_FRAC) begin : g_bad_frac
      $error("fir_shift_add: FRAC_G must cover the deepest coefficient shift");
   end
   if (INT_G < 1) begin : g_bad_int
      $error("fir_shift_add: INT_G must hold a coefficient sum of magnitude below 2");
   end
   if (ACC_W > 64) begin : g_bad_acc
      $error("fir_shift_add: accumulator wider than 64 bits");
   end

   logic [HIST_N-1:0][IN_W-1:0]   hist;
   logic [NUM_TAPS-1:0][IN_W-1:0] samples;
   logic signed [ACC_W-1:0]       acc;
   logic [IN_W-1:0]               sat_sample;

   fir_sa_delay #(
      .W     (IN_W),
      .DEPTH (HIST_N)
   ) u_delay (
      .clk      (clk),
      .rst      (rst),
      .shift_i  (in_valid),
      .sample_i (in_sample),
      .taps_o   (hist)
   );

   assign samples[0] = in_sample;
   for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap_map
      assign samples[k] = hist[k-1];
   end

   fir_sa_network #(
      .IN_W      (IN_W),
      .FRAC_G    (FRAC_G),
      .INT_G     (INT_G),
      .SHARE_SUM (SHARE_SUM)
   ) u_network (
      .samples_i (samples),
      .acc_o     (acc)
   );

   fir_sa_saturate #(
      .IN_W   (IN_W),
      .FRAC_G (FRAC_G),
      .INT_G  (INT_G)
   ) u_saturate (
      .acc_i    (acc),
      .sample_o (sat_sample)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sample <= sat_sample;
         end
      end
   end

   // Multiplying reference of the inner product, for the checks only.
   logic signed [ACC_W-1:0] ref_acc;
   always_comb begin
      ref_acc = ACC_W'(longint'($signed(samples[0])) * WEIGHT_0
                     + longint'($signed(samples[1])) * WEIGHT_1
                     + longint'($signed(samples[2])) * WEIGHT_2
                     + longint'($signed(samples[3])) * WEIGHT_3) <<< (FRAC_G - WEIGHT_FRAC);
   end

   // R3: shift-add network equals the exact weighted sum (no internal overflow)
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> acc == ref_acc);

   // R5: strobe delayed by one clock
   a_r5_valid_follow: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r5_valid_drop: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   a_r5_hold_out: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_sample));

   // R6 / R7: out-of-range results clamp to the matching rail
   a_r6_sat_high: assert property (@(posedge clk) disable iff (rst)
      (in_valid && acc >= SAT_HI) |=> out_sample == {1'b0, {(IN_W-1){1'b1}}});
   a_r7_sat_low: assert property (@(posedge clk) disable iff (rst)
      (in_valid && acc < SAT_LO) |=> out_sample == {1'b1, {(IN_W-1){1'b0}}});

endmodule

// File: tb/fir_shift_add_tb.sv
module fir_shift_add_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [15:0] in_sample;
   logic        out_valid;
   logic [15:0] out_sample;

   int checks = 0;
   int errors = 0;
   int h1 = 0, h2 = 0, h3 = 0;
   int last_out = 0;
   int unsigned lfsr = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   fir_shift_add u_dut (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   function automatic int ref_out(input int a, input int b, input int c, input int d);
      int acc;
      int q;
      acc = 59*a + 46*b - 77*c + 38*d;
      q   = acc >>> 7;
      if (q > 32767)  q = 32767;
      if (q < -32768) q = -32768;
      return q;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drive one cycle at a falling edge, check after the next falling edge.
   task automatic drive(input bit v, input int s, input string req);
      int exp;
      string tag;
      in_valid  = v;
      in_sample = s[15:0];
      @(posedge clk);
      @(negedge clk);
      check(out_valid == v, "R5 out_valid", int'(out_valid), int'(v));
      if (v) begin
         exp = ref_out(s, h1, h2, h3);
         tag = req;
         if (exp == 32767 && 59*s + 46*h1 - 77*h2 + 38*h3 >= 32768*128) tag = "R6 sat high";
         if (exp == -32768 && 59*s + 46*h1 - 77*h2 + 38*h3 < -32768*128) tag = "R7 sat low";
         check(int'($signed(out_sample)) == exp, tag, int'($signed(out_sample)), exp);
         h3 = h2; h2 = h1; h1 = s;
         last_out = exp;
      end else begin
         check(int'($signed(out_sample)) == last_out, "R5/R2 hold while idle",
               int'($signed(out_sample)), last_out);
      end
   endtask

   task automatic do_reset(input int garbage);
      rst       = 1'b1;
      in_valid  = 1'b1;
      in_sample = garbage[15:0];
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
      check(out_sample == 16'h0, "R1 reset data", int'($signed(out_sample)), 0);
      rst = 1'b0;
      in_valid = 1'b0;
      h1 = 0; h2 = 0; h3 = 0;
      last_out = 0;
   endtask

   initial begin
      rst = 1'b1;
      in_valid = 1'b0;
      in_sample = '0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
      check(out_sample == 16'h0, "R1 reset data", int'($signed(out_sample)), 0);
      rst = 1'b0;

      // R3: impulse exposes each weight: 7552, 5888, -9856, 4864, 0
      drive(1, 16384, "R3 impulse w0");
      drive(1, 0, "R3 impulse w1");
      drive(1, 0, "R3 impulse w2");
      drive(1, 0, "R3 impulse w3");
      drive(1, 0, "R3 impulse flushed");
      // negative impulse
      drive(1, -20000, "R3 neg impulse");
      for (int i = 0; i < 4; i++) drive(1, 0, "R3 neg impulse tail");

      // R4: floor rounding of single LSB inputs
      drive(1, -1, "R4 floor minus one LSB");
      for (int i = 0; i < 3; i++) drive(1, 0, "R4 flush");
      drive(1, 1, "R4 floor plus one LSB");
      for (int i = 0; i < 3; i++) drive(1, 0, "R4 flush");

      // R2: garbage on idle cycles must not enter history
      drive(1, 1000, "R2 before gap");
      drive(0, 32767, "R2 idle");
      drive(0, -32768, "R2 idle");
      drive(0, 12345, "R2 idle");
      drive(1, -3000, "R2 after gap");
      drive(1, 500, "R2 after gap");

      // R6: worst-case positive mix (+, +, -, + from newest)
      drive(1, 32767, "R6 setup");
      drive(1, -32768, "R6 setup");
      drive(1, 32767, "R6 setup");
      drive(1, 32767, "R6 sat high");
      // R7: worst-case negative mix
      drive(1, -32768, "R7 setup");
      drive(1, 32767, "R7 setup");
      drive(1, -32768, "R7 setup");
      drive(1, -32768, "R7 sat low");
      // full-scale constant runs (no saturation, exact level)
      for (int i = 0; i < 6; i++) drive(1, 32767, "R3 full-scale positive run");
      for (int i = 0; i < 6; i++) drive(1, -32768, "R3 full-scale negative run");

      // R1: mid-run reset clears history
      do_reset(22222);
      drive(1, 1000, "R1 history cleared");

      // Pseudo-random sweep with gaps and occasional rail values
      for (int i = 0; i < 3000; i++) begin
         int s;
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         s = int'($signed(lfsr[15:0]));
         if (lfsr[20:18] == 3'd0) s = 32767;
         if (lfsr[20:18] == 3'd1) s = -32768;
         drive(lfsr[23:21] != 3'd0, s, "R3 random sweep");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule